// File: doc/BRIEF.md
# Paired-Byte Word Write Controller

This block connects an 8-bit core that issues byte-wide table writes to an external word-wide memory. The memory sits on a multiplexed 16-bit address/data bus. Each request carries a byte address and a data byte. Bit 0 of the address decides what the block does with the request.

An even-address request loads the byte into an internal holding latch. Its bus cycle runs without any write strobe, and the data lines float during the data phase. The next odd-address request produces one full word write: the new byte goes on the upper half of the bus and the held byte on the lower half. The high-write strobe is pulsed, and both byte selects are asserted. Software must therefore write each word as an even/odd pair on the same word boundary. An odd write that is not paired this way still goes out, using whatever the latch last held, and a status flag reports the mismatch.

Every bus cycle has the same shape:
- an address phase, with the address-latch pulse high and the word address on the data lines;
- one cycle with the latch pulse low while the address is still driven;
- a data-setup cycle;
- the strobe window;
- a recovery cycle.

The core sees a ready signal and may hand over a new request only when the previous cycle has finished.

Top module: `word_pair_writer`

## Requirements
- R1: In the first cycle after a request is accepted, `ale` is high for exactly one cycle, `ad_oe` is high and `ad_out` carries byte-address bits [16:1]. `ale` stays low for the rest of the bus cycle.
- R2: A request with address bit 0 = 0 stores its byte in the holding latch and asserts no `wrh` pulse. Its four data-phase cycles (setup, two strobe-window cycles, recovery) have `ad_oe` low.
- R3: A request with address bit 0 = 1 drives `ad_out` = {request byte, holding latch} with `ad_oe` high through all four data-phase cycles. `wrh` is high for STROBE_LEN (default 2) cycles, and `ad_out` is stable while `wrh` is high.
- R4: `wrl` is never asserted. Whenever `wrh` is high, `ub` and `lb` are both high.
- R5: `ba0` equals bit 0 of the accepted address in every cycle of that bus cycle.
- R6: In the address phase, `hi_oe` equals `cfg_addr20` and `hi_addr` carries address bits [20:17] when `cfg_addr20` = 1. When `cfg_addr20` = 0, `hi_oe` is 0 and `hi_addr` is 0.
- R7: After an odd request, `pair_unmatched` is 0 if the most recent accepted request was even and in the same word. Otherwise it is 1, and the low byte is the latch's previous contents. After an even request, `pair_unmatched` is 0.
- R8: `req_ready` is high only when idle. A bus cycle keeps it low for 4 + STROBE_LEN (default 6) cycles. Requests raised while it is low are ignored.
- R9: During and after reset the holding latch is 0, `ad_oe`, `ale`, `wrh`, `ub` and `lb` are low, and `req_ready` is high.
- R10: `wrh` never overlaps `ale`. The data is driven for one full cycle before `wrh` rises and stays driven in the cycle after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr20 | input | 1 | 1 drives the four upper address lines during the address phase |
| req_valid | input | 1 | Write request from the core |
| req_addr | input | 21 | Byte address of the request |
| req_data | input | 8 | Data byte of the request |
| req_ready | output | 1 | Idle; a request is accepted when both valid and ready are high |
| pair_unmatched | output | 1 | Last odd write was not preceded by an even write to the same word |
| ale | output | 1 | Address latch enable pulse |
| ad_out | output | 16 | Multiplexed address/data value |
| ad_oe | output | 1 | Drive enable for `ad_out` (0 = tri-stated) |
| hi_addr | output | 4 | Upper address bits [20:17] |
| hi_oe | output | 1 | Drive enable for `hi_addr` |
| ba0 | output | 1 | Byte-address bit 0 of the current cycle |
| wrh | output | 1 | High-write strobe |
| wrl | output | 1 | Low-write strobe, held inactive |
| ub | output | 1 | Upper byte select |
| lb | output | 1 | Lower byte select |

## Verification
The assertions assume that `cfg_addr20` does not change while a bus cycle is in progress, because the upper-line enable is checked against its live value. They also assume that request inputs change only away from the active clock edge. The stimulus sets the configuration and the request together, on a falling edge while the block is idle. It then withdraws the request after one cycle. The only deliberate exception is the busy-overlap test, where a request is held during a bus cycle and must be ignored.

// File: rtl/wpw_pkg.sv
// Package: shared types for the paired-byte word write controller.
// Assumes nothing beyond a single clock domain.
package wpw_pkg;

    // Bus cycle phases, in the order the sequencer walks them.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_HOLD   = 3'd2,
        PH_SETUP  = 3'd3,
        PH_STROBE = 3'd4,
        PH_RECOV  = 3'd5
    } wpw_phase_t;

endpackage

// File: rtl/wpw_seq.sv
// Module: bus-cycle sequencer.
// Walks one bus cycle per accepted request:
//   address, hold, setup, STROBE_LEN strobe-window cycles, recovery.
// Assumes start is only raised while idle.
module wpw_seq
    import wpw_pkg::*;
#(
    parameter int STROBE_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output wpw_phase_t phase,
    output logic       idle
);
    localparam int CNT_W = (STROBE_LEN > 1) ? $clog2(STROBE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_LEN - 1);

    wpw_phase_t       phase_q;
    wpw_phase_t       phase_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-phase decode.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (start) phase_d = PH_ADDR;
            PH_ADDR:   phase_d = PH_HOLD;
            PH_HOLD:   phase_d = PH_SETUP;
            PH_SETUP:  phase_d = PH_STROBE;
            PH_STROBE: if (cnt_q == CNT_LAST) phase_d = PH_RECOV;
            PH_RECOV:  phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Strobe-window length counter: cleared outside the window, counts inside it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (phase_q == PH_STROBE) cnt_q <= cnt_q + 1'b1;
        else                           cnt_q <= '0;
    end

    assign phase = phase_q;
    assign idle  = (phase_q == PH_IDLE);
endmodule

// File: rtl/wpw_latch.sv
// Module: request capture, holding latch and pairing tracker.
// Captures each accepted request. An even address also loads the holding
// latch and remembers its word. An odd address checks whether it completes
// that remembered word.
// Assumes accept is a single-cycle qualifier of a valid request.
module wpw_latch #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_data,
    output logic [DATA_W-1:0] hold_byte,
    output logic              unmatched
);
    localparam int WORD_W = ADDR_W - 1;

    logic [WORD_W-1:0] pend_word_q;
    logic              pend_q;
    logic              req_odd;
    logic              pair_ok;

    assign req_odd = req_addr[0];
    assign pair_ok = pend_q && (pend_word_q == req_addr[ADDR_W-1:1]);

    // Current-request registers, refreshed on each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_data <= '0;
        end else if (accept) begin
            cur_addr <= req_addr;
            cur_data <= req_data;
        end
    end

    // Holding latch and pairing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_byte   <= '0;
            pend_q      <= 1'b0;
            pend_word_q <= '0;
            unmatched   <= 1'b0;
        end else if (accept) begin
            if (!req_odd) begin
                hold_byte   <= req_data;
                pend_q      <= 1'b1;
                pend_word_q <= req_addr[ADDR_W-1:1];
                unmatched   <= 1'b0;
            end else begin
                pend_q      <= 1'b0;
                unmatched   <= !pair_ok;
            end
        end
    end
endmodule

// File: rtl/wpw_pins.sv
// Module: pin driver decode.
// Turns the phase and the captured request into bus pin values.
// Purely combinational from registered state, so the pins change only
// after clock edges.
// Assumes cfg_addr20 is steady while a bus cycle runs.
module wpw_pins
    import wpw_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  wpw_phase_t            phase,
    input  logic                  cfg_addr20,
    input  logic [ADDR_W-1:0]     cur_addr,
    input  logic [DATA_W-1:0]     cur_data,
    input  logic [DATA_W-1:0]     hold_byte,
    output logic                  ale,
    output logic [2*DATA_W-1:0]   ad_out,
    output logic                  ad_oe,
    output logic [ADDR_W-2*DATA_W-2:0] hi_addr,
    output logic                  hi_oe,
    output logic                  ba0,
    output logic                  wrh,
    output logic                  wrl,
    output logic                  ub,
    output logic                  lb
);
    localparam int AD_W = 2 * DATA_W;
    localparam int HI_W = ADDR_W - AD_W - 1;

    logic odd;
    logic addr_phase;
    logic data_phase;

    assign odd        = cur_addr[0];
    assign addr_phase = (phase == PH_ADDR) || (phase == PH_HOLD);
    assign data_phase = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_RECOV);

    // Multiplexed lines: address in the address phase, word data for odd writes.
    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        if (addr_phase) begin
            ad_out = cur_addr[AD_W:1];
            ad_oe  = 1'b1;
        end else if (data_phase && odd) begin
            ad_out = {cur_data, hold_byte};
            ad_oe  = 1'b1;
        end
    end

    // Upper address lines, driven only in the address phase of the wide configuration.
    always_comb begin
        hi_oe   = addr_phase && cfg_addr20;
        hi_addr = hi_oe ? cur_addr[ADDR_W-1:AD_W+1] : {HI_W{1'b0}};
    end

    // Control strobes.
    always_comb begin
        ale = (phase == PH_ADDR);
        wrh = (phase == PH_STROBE) && odd;
        ub  = data_phase && odd;
        lb  = data_phase && odd;
        ba0 = (phase != PH_IDLE) && odd;
    end

    assign wrl = 1'b0;
endmodule

// File: rtl/word_pair_writer.sv
// Module: paired-byte word write controller (top).
// Accepts byte writes from the core. Even addresses fill the holding latch;
// odd addresses emit one 16-bit word write on the multiplexed bus.
// Assumes requests follow a valid/ready handshake, and that cfg_addr20 is
// steady during a bus cycle.
module word_pair_writer
    import wpw_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 8,
    parameter int STROBE_LEN = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_addr20,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_data,
    output logic                        req_ready,
    output logic                        pair_unmatched,
    output logic                        ale,
    output logic [2*DATA_W-1:0]         ad_out,
    output logic                        ad_oe,
    output logic [ADDR_W-2*DATA_W-2:0]  hi_addr,
    output logic                        hi_oe,
    output logic                        ba0,
    output logic                        wrh,
    output logic                        wrl,
    output logic                        ub,
    output logic                        lb
);
    localparam int AD_W = 2 * DATA_W;
    localparam int HI_W = ADDR_W - AD_W - 1;

    wpw_phase_t        phase;
    logic              idle;
    logic              accept;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;
    logic [DATA_W-1:0] hold_byte;

    assign accept    = req_valid && idle;
    assign req_ready = idle;

    wpw_seq #(.STROBE_LEN(STROBE_LEN)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .phase (phase),
        .idle  (idle)
    );

    wpw_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .cur_addr  (cur_addr),
        .cur_data  (cur_data),
        .hold_byte (hold_byte),
        .unmatched (pair_unmatched)
    );

    wpw_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase      (phase),
        .cfg_addr20 (cfg_addr20),
        .cur_addr   (cur_addr),
        .cur_data   (cur_data),
        .hold_byte  (hold_byte),
        .ale        (ale),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .hi_addr    (hi_addr),
        .hi_oe      (hi_oe),
        .ba0        (ba0),
        .wrh        (wrh),
        .wrl        (wrl),
        .ub         (ub),
        .lb         (lb)
    );
endmodule

// File: rtl/wpw_checker.sv
// Module: protocol checker for word_pair_writer, attached with bind.
// Observes the top-level ports only.
// Assumes cfg_addr20 is steady during bus cycles.
module wpw_checker #(
    parameter int AD_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_addr20,
    input logic            req_ready,
    input logic            ale,
    input logic [AD_W-1:0] ad_out,
    input logic            ad_oe,
    input logic            hi_oe,
    input logic            ba0,
    input logic            wrh,
    input logic            ub,
    input logic            lb
);
    // R1: the latch pulse lasts one cycle, with the bus driven and the block busy
    a_r1_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    a_r1_ale_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && !req_ready));

    // R2: a write strobe only occurs for an odd byte address
    a_r2_even_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wrh |-> ba0);

    // R3: word data holds still while the strobe is high
    a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wrh && $past(wrh)) |-> $stable(ad_out));

    // R4: both byte selects accompany the strobe
    a_r4_both_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        wrh |-> (ub && lb));

    // R6: upper lines are driven only in the wide configuration
    a_r6_hi_gated: assert property (@(posedge clk) disable iff (!rst_n)
        hi_oe |-> cfg_addr20);

    // R8: no strobe while the block reports ready
    a_r8_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wrh |-> !req_ready);

    // R9: reset leaves the bus released and the strobes low
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!ad_oe && !ale && !wrh && !ub && !lb && req_ready));

    // R10: the strobe avoids the address phase and is framed by driven data
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        wrh |-> !ale);
    a_r10_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrh) |-> $past(ad_oe));
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrh) |-> ad_oe);
endmodule

bind word_pair_writer wpw_checker #(.AD_W(AD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_addr20 (cfg_addr20),
    .req_ready  (req_ready),
    .ale        (ale),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .hi_oe      (hi_oe),
    .ba0        (ba0),
    .wrh        (wrh),
    .ub         (ub),
    .lb         (lb)
);

// File: tb/sim_word_pair_writer.sv
`timescale 1ns/1ps
module sim_word_pair_writer;
    localparam int STROBE_LEN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_addr20 = 1'b0;
    logic        req_valid = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_ready, pair_unmatched, ale, ad_oe, hi_oe, ba0, wrh, wrl, ub, lb;
    logic [15:0] ad_out;
    logic [3:0]  hi_addr;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    word_pair_writer #(.STROBE_LEN(STROBE_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr20(cfg_addr20),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .pair_unmatched(pair_unmatched),
        .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe),
        .hi_addr(hi_addr), .hi_oe(hi_oe), .ba0(ba0),
        .wrh(wrh), .wrl(wrl), .ub(ub), .lb(lb)
    );

    typedef struct packed {
        logic        cfg;
        logic [20:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp_low;
        logic        exp_unm;
    } vec_t;

    // Stimulus and expected low byte / unmatched flag, applied after reset.
    localparam vec_t VEC [10] = '{
        '{1'b0, 21'h000001, 8'hA5, 8'h00, 1'b1},  // odd first after reset
        '{1'b0, 21'h000010, 8'h34, 8'h00, 1'b0},  // even
        '{1'b0, 21'h000011, 8'h12, 8'h34, 1'b0},  // matched odd
        '{1'b1, 21'h1A5678, 8'h77, 8'h00, 1'b0},  // even, wide address
        '{1'b1, 21'h1A5679, 8'h9C, 8'h77, 1'b0},  // matched odd, wide address
        '{1'b0, 21'h000020, 8'h55, 8'h00, 1'b0},  // even
        '{1'b0, 21'h000033, 8'h66, 8'h55, 1'b1},  // odd, other word
        '{1'b0, 21'h000040, 8'hEE, 8'h00, 1'b0},  // even
        '{1'b0, 21'h000042, 8'hDD, 8'h00, 1'b0},  // even, replaces latch
        '{1'b0, 21'h000043, 8'h11, 8'hDD, 1'b0}   // odd, pairs with last even
    };

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic run_write(input logic cfg, input logic [20:0] a, input logic [7:0] d,
                             input logic [7:0] exp_low, input logic exp_unm);
        int n = 1;
        int strobes = 0;
        int tri_cnt = 0;
        int ale_extra = 0;
        int bad_ba0 = 0;
        int bad_sel = 0;
        logic [15:0] pat = '0;
        logic [15:0] word = '0;
        @(negedge clk);
        cfg_addr20 = cfg; req_addr = a; req_data = d; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale && ad_oe, "R1 address phase pins", {ale, ad_oe}, 2'b11);
        chk(ad_out == a[16:1], "R1 word address on AD", ad_out, a[16:1]);
        chk(hi_oe == cfg && hi_addr == (cfg ? a[20:17] : 4'h0), "R6 upper lines",
            {hi_oe, hi_addr}, {cfg, (cfg ? a[20:17] : 4'h0)});
        chk(ba0 == a[0], "R5 ba0 in address phase", ba0, a[0]);
        chk(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);
        while (n < 20) begin
            @(negedge clk);
            n++;
            if (req_ready) break;
            if (ale) ale_extra++;
            if (ba0 != a[0]) bad_ba0++;
            if (wrl) bad_sel++;
            if (wrh) begin
                strobes++;
                pat[n] = 1'b1;
                word = ad_out;
                if (!(ub && lb)) bad_sel++;
            end
            if (n >= 3 && !ad_oe) tri_cnt++;
        end
        chk(n == 7, "R8 bus cycle length", n, 7);
        chk(ale_extra == 0, "R1 single ale pulse", ale_extra, 0);
        chk(bad_ba0 == 0, "R5 ba0 through cycle", bad_ba0, 0);
        chk(bad_sel == 0, "R4 wrl low and ub/lb with wrh", bad_sel, 0);
        if (a[0]) begin
            chk(strobes == STROBE_LEN, "R3 strobe count", strobes, STROBE_LEN);
            chk(pat == 16'h0030, "R10 strobe position", pat, 16'h0030);
            chk(word == {d, exp_low}, "R3 R7 word on bus", word, {d, exp_low});
            chk(tri_cnt == 0, "R3 data driven", tri_cnt, 0);
        end else begin
            chk(strobes == 0, "R2 no strobe on even", strobes, 0);
            chk(tri_cnt == 4, "R2 tri-state data phase", tri_cnt, 4);
        end
        chk(pair_unmatched == exp_unm, "R7 unmatched flag", pair_unmatched, exp_unm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!ad_oe && !ale && !wrh && !ub && !lb, "R9 bus idle in reset",
            {ad_oe, ale, wrh, ub, lb}, 0);
        chk(req_ready == 1'b1, "R9 ready in reset", req_ready, 1);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++)
            run_write(VEC[i].cfg, VEC[i].addr, VEC[i].data, VEC[i].exp_low, VEC[i].exp_unm);

        // R8: a request held while busy is ignored
        @(negedge clk);
        req_addr = 21'h000060; req_data = 8'h44; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 21'h000061; req_data = 8'hFF;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(!ale && !wrh && req_ready, "R8 busy request ignored", {ale, wrh, req_ready}, 3'b001);
        run_write(1'b0, 21'h000061, 8'h22, 8'h44, 1'b0);

        // R9: reset clears the holding latch
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!ad_oe && !wrh && req_ready, "R9 idle after reset", {ad_oe, wrh, req_ready}, 3'b001);
        rst_n = 1'b1;
        run_write(1'b0, 21'h000071, 8'h3C, 8'h00, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule